// File: doc/BRIEF.md
# Unaligned Write Splitter for a 64-bit Word Bus

This block takes one write from a requester and turns it into bus transactions on a 64-bit bus. The write can be 1, 2, 4 or 8 bytes long and can start at any byte address. On this bus every transaction address sits on an 8-byte boundary. Each transaction has two phases. The address phase carries an ID and a length field and waits for the target to accept it. The data phase is a single beat that carries the write data, a per-byte lane enable mask and the same ID.

The requester's bytes are shifted onto the lanes they belong to. A write that fits inside one aligned word produces one transaction, and only that write's lanes are enabled. A write that crosses a word boundary produces two complete transactions: the first at the lower word, the second at the next word, each with its own mask. The address phase of the second transaction is not raised until the data beat of the first has been accepted. With the response channel enabled (the default), the single done pulse to the requester waits until one response has arrived for every transaction issued.

Top module: `wsp_top`

## Requirements
- R1: Every address phase presents an address whose three low bits are zero. The first transaction's address is the request address with its three low bits cleared.
- R2: Size encoding: `req_size_i` values 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. A write whose last byte stays inside the first word issues exactly one transaction. Its lane mask has the request's byte count of ones, starting at lane (address mod 8). The length field is 0, meaning one beat.
- R3: Request byte i (bits 8i+7..8i of `req_data_i`) appears on lane (offset+i) mod 8 of the transaction that covers position offset+i, where positions 0..7 belong to the first transaction and 8..15 to the second. Every disabled lane carries zero, including request bytes beyond the size.
- R4: A write that crosses an 8-byte boundary issues two transactions. The second transaction's address is the first's plus 8. The first transaction enables lanes from the offset up to lane 7. The second enables lanes from lane 0 upward, for the overflow bytes.
- R5: The address phase and the data phase are never valid in the same cycle. A data beat is presented only after its address phase has been accepted. The second address phase starts only after the first data beat has been accepted.
- R6: Once a valid is raised on the address or data channel, it stays high with a stable payload until the target accepts.
- R7: The 4-bit ID is 0 after reset and increases by one, modulo 16, for each transaction. A data beat carries the same ID as its address phase.
- R8: `b_ready_o` is high while a write is in progress. Completion needs one response per transaction issued.
- R9: `req_done_o` is a one-cycle pulse in the cycle after the final response handshake. `req_ready_o` is low from the accepted request until that pulse.
- R10: During and after reset, `aw_valid_o`, `w_valid_o`, `b_ready_o` and `req_done_o` are low and `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Write request present |
| req_ready_o | output | 1 | Splitter idle, accepts a request |
| req_addr_i | input | AW | Byte address of the write |
| req_size_i | input | 2 | Log2 of the byte count |
| req_data_i | input | DW | Write data, byte 0 in the low bits |
| req_done_o | output | 1 | Write complete pulse |
| aw_valid_o | output | 1 | Address phase valid |
| aw_ready_i | input | 1 | Address phase accepted |
| aw_addr_o | output | AW | Word-aligned transaction address |
| aw_id_o | output | IDW | Transaction ID |
| aw_len_o | output | LENW | Beats minus one, always 0 |
| w_valid_o | output | 1 | Data beat valid |
| w_ready_i | input | 1 | Data beat accepted |
| w_data_o | output | DW | Lane-aligned data |
| w_strb_o | output | DW/8 | Byte-lane enables |
| w_id_o | output | IDW | ID of the data beat |
| w_last_o | output | 1 | Last beat marker, always 1 |
| b_valid_i | input | 1 | Write response present |
| b_ready_o | output | 1 | Response accepted |

## Verification
The assertions assume a target that follows the bus handshake. It raises each ready only while the matching valid is high, and it returns at most one response per data beat it has accepted, never before that beat. They also assume the requester holds its address, size and data steady while valid is high and not yet accepted. The bench acts as that target. Each ready is raised only after a per-vector stall count of cycles, with the valid observed high. A response is queued only after a data handshake has been recorded. The requester fields are changed only once the block is idle again.

// File: rtl/wsp_pkg.sv
package wsp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_RESP = 2'd3
  } wsp_state_e;
endpackage

// File: rtl/wsp_lane_map.sv
module wsp_lane_map #(
  parameter int AW   = 32,
  parameter int DW   = 64,
  localparam int NB   = DW / 8,
  localparam int OFFW = $clog2(NB),
  localparam int SZW  = $clog2(OFFW + 1)
) (
  input  logic [AW-1:0]  addr_i,
  input  logic [SZW-1:0] size_i,
  input  logic [DW-1:0]  data_i,
  output logic [AW-1:0]  base0_o,
  output logic [AW-1:0]  base1_o,
  output logic [NB-1:0]  strb0_o,
  output logic [NB-1:0]  strb1_o,
  output logic [DW-1:0]  data0_o,
  output logic [DW-1:0]  data1_o,
  output logic           split_o
);
  logic [OFFW-1:0]  off;
  logic [NB-1:0]    keep;
  logic [DW-1:0]    dmask;
  logic [2*NB-1:0]  lanes;
  logic [2*DW-1:0]  wide;

  assign off = addr_i[OFFW-1:0];

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign keep[b] = (b < (1 << size_i));
    // unused bytes forced to zero so idle lanes are deterministic
    assign dmask[b*8 +: 8] = keep[b] ? data_i[b*8 +: 8] : 8'h00;
  end

  assign lanes = {{NB{1'b0}}, keep} << off;
  assign wide  = {{DW{1'b0}}, dmask} << {off, 3'b000};

  assign strb0_o = lanes[NB-1:0];
  assign strb1_o = lanes[2*NB-1:NB];
  assign data0_o = wide[DW-1:0];
  assign data1_o = wide[2*DW-1:DW];
  assign split_o = |strb1_o;

  assign base0_o = {addr_i[AW-1:OFFW], {OFFW{1'b0}}};
  assign base1_o = base0_o + AW'(NB);
endmodule

// File: rtl/wsp_seq.sv
module wsp_seq
  import wsp_pkg::*;
#(
  parameter int IDW      = 4,
  parameter bit USE_RESP = 1'b1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           split_i,
  input  logic           aw_ready_i,
  input  logic           w_ready_i,
  input  logic           b_valid_i,
  output logic           seg_o,
  output logic           aw_valid_o,
  output logic           w_valid_o,
  output logic           b_ready_o,
  output logic           busy_o,
  output logic           done_o,
  output logic [IDW-1:0] id_o
);
  wsp_state_e st_q, st_d;
  logic seg_q, done_q, resp_ok;
  logic [IDW-1:0] id_q;
  logic aw_fire, w_fire;

  assign aw_valid_o = (st_q == ST_ADDR);
  assign w_valid_o  = (st_q == ST_DATA);
  assign busy_o     = (st_q != ST_IDLE);
  assign aw_fire    = aw_valid_o & aw_ready_i;
  assign w_fire     = w_valid_o & w_ready_i;
  assign seg_o      = seg_q;
  assign done_o     = done_q;
  assign id_o       = id_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_ADDR;
      ST_ADDR: if (aw_ready_i) st_d = ST_DATA;
      ST_DATA: if (w_ready_i) st_d = (split_i && !seg_q) ? ST_ADDR : ST_RESP;
      ST_RESP: if (resp_ok) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      seg_q  <= 1'b0;
      id_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == ST_RESP) && resp_ok;
      if (start_i) seg_q <= 1'b0;
      else if (w_fire && split_i && !seg_q) seg_q <= 1'b1;
      if (w_fire) id_q <= id_q + 1'b1;
    end
  end

  if (USE_RESP) begin : g_resp
    logic [1:0] cnt_q, cnt_nxt, need;
    assign need      = split_i ? 2'd2 : 2'd1;
    assign b_ready_o = busy_o;
    assign cnt_nxt   = cnt_q + {1'b0, b_valid_i & b_ready_o};
    assign resp_ok   = (cnt_nxt >= need);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_q <= '0;
      else if (start_i) cnt_q <= '0;
      else              cnt_q <= cnt_nxt;
    end

    // R8: no more responses than transactions
    assert_resp_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (b_valid_i && b_ready_o) |-> (cnt_q < need));
  end else begin : g_noresp
    assign resp_ok   = 1'b1;
    assign b_ready_o = 1'b0;
  end

  assert_phase_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(aw_valid_o && w_valid_o));
  assert_id_tag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aw_fire |=> (w_valid_o && id_o == $past(id_o)));
  assert_second_after_beat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_fire && split_i && !seg_q) |=> (aw_valid_o && seg_o));
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/wsp_top.sv
module wsp_top #(
  parameter int AW       = 32,
  parameter int DW       = 64,
  parameter int IDW      = 4,
  parameter int LENW     = 8,
  parameter bit USE_RESP = 1'b1,
  localparam int NB   = DW / 8,
  localparam int OFFW = $clog2(NB),
  localparam int SZW  = $clog2(OFFW + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [SZW-1:0]  req_size_i,
  input  logic [DW-1:0]   req_data_i,
  output logic            req_done_o,
  output logic            aw_valid_o,
  input  logic            aw_ready_i,
  output logic [AW-1:0]   aw_addr_o,
  output logic [IDW-1:0]  aw_id_o,
  output logic [LENW-1:0] aw_len_o,
  output logic            w_valid_o,
  input  logic            w_ready_i,
  output logic [DW-1:0]   w_data_o,
  output logic [NB-1:0]   w_strb_o,
  output logic [IDW-1:0]  w_id_o,
  output logic            w_last_o,
  input  logic            b_valid_i,
  output logic            b_ready_o
);
  logic [AW-1:0]  addr_q, base0, base1;
  logic [SZW-1:0] size_q;
  logic [DW-1:0]  data_q, data0, data1;
  logic [NB-1:0]  strb0, strb1;
  logic           split, seg, busy, start;
  logic [IDW-1:0] id;

  assign start = req_valid_i & req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      size_q <= '0;
      data_q <= '0;
    end else if (start) begin
      addr_q <= req_addr_i;
      size_q <= req_size_i;
      data_q <= req_data_i;
    end
  end

  wsp_lane_map #(.AW(AW), .DW(DW)) u_map (
    .addr_i (addr_q),
    .size_i (size_q),
    .data_i (data_q),
    .base0_o(base0),
    .base1_o(base1),
    .strb0_o(strb0),
    .strb1_o(strb1),
    .data0_o(data0),
    .data1_o(data1),
    .split_o(split)
  );

  wsp_seq #(.IDW(IDW), .USE_RESP(USE_RESP)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .split_i   (split),
    .aw_ready_i(aw_ready_i),
    .w_ready_i (w_ready_i),
    .b_valid_i (b_valid_i),
    .seg_o     (seg),
    .aw_valid_o(aw_valid_o),
    .w_valid_o (w_valid_o),
    .b_ready_o (b_ready_o),
    .busy_o    (busy),
    .done_o    (req_done_o),
    .id_o      (id)
  );

  assign req_ready_o = !busy;
  assign aw_addr_o   = seg ? base1 : base0;
  assign aw_id_o     = id;
  assign aw_len_o    = '0;
  assign w_data_o    = seg ? data1 : data0;
  assign w_strb_o    = seg ? strb1 : strb0;
  assign w_id_o      = id;
  assign w_last_o    = 1'b1;

  assert_aw_aligned_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aw_valid_o |-> (aw_addr_o[OFFW-1:0] == '0));
  assert_aw_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aw_valid_o && !aw_ready_i) |=> (aw_valid_o && $stable(aw_addr_o) && $stable(aw_id_o)));
  assert_w_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_valid_o && !w_ready_i) |=> (w_valid_o && $stable(w_data_o) && $stable(w_strb_o)));
  assert_lane_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_valid_o && !split) |-> ($countones(w_strb_o) == (1 << size_q)));
  assert_split_edges_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_valid_o && split) |-> (seg ? w_strb_o[0] : w_strb_o[NB-1]));
  assert_ready_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aw_valid_o || w_valid_o) |-> !req_ready_o);
endmodule

// File: tb/tb_wsp_top.sv
`timescale 1ns/1ps
module tb_wsp_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_done;
  logic [31:0] req_addr;
  logic [1:0]  req_size;
  logic [63:0] req_data;
  logic        aw_valid, aw_ready;
  logic [31:0] aw_addr;
  logic [3:0]  aw_id, w_id;
  logic [7:0]  aw_len, w_strb;
  logic        w_valid, w_ready, w_last;
  logic [63:0] w_data;
  logic        b_valid, b_ready;

  int total = 0;
  int bad   = 0;
  logic [3:0] exp_id = 4'd0;

  always #2 clk = ~clk;

  wsp_top dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_data_i(req_data),
    .req_done_o(req_done),
    .aw_valid_o(aw_valid), .aw_ready_i(aw_ready), .aw_addr_o(aw_addr),
    .aw_id_o(aw_id), .aw_len_o(aw_len),
    .w_valid_o(w_valid), .w_ready_i(w_ready), .w_data_o(w_data),
    .w_strb_o(w_strb), .w_id_o(w_id), .w_last_o(w_last),
    .b_valid_i(b_valid), .b_ready_o(b_ready)
  );

  localparam int NV = 10;
  localparam logic [31:0] V_ADDR [NV] = '{32'h1000, 32'h1004, 32'h1001, 32'h1007, 32'h2003,
                                          32'h2006, 32'h3005, 32'h300F, 32'h4000, 32'h4009};
  localparam logic [1:0]  V_SIZE [NV] = '{2'd3, 2'd3, 2'd1, 2'd1, 2'd2, 2'd2, 2'd0, 2'd3, 2'd0, 2'd3};
  localparam logic [63:0] V_DATA [NV] = '{64'h8877665544332211, 64'hF0E0D0C0B0A09080,
                                          64'h000000000000BEEF, 64'h000000000000CAFE,
                                          64'h00000000DEADBEEF, 64'h0000000012345678,
                                          64'h00000000000000A5, 64'h0102030405060708,
                                          64'hFFFFFFFFFFFFFF3C, 64'h1122334455667788};
  localparam int          V_STALL[NV] = '{0, 1, 0, 2, 2, 0, 1, 3, 0, 1};

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic run_write(input logic [31:0] a, input logic [1:0] sz,
                           input logic [63:0] d, input int stall);
    logic [63:0] e_d [2];
    logic [7:0]  e_s [2];
    logic [31:0] g_a [2];
    logic [63:0] g_d [2];
    logic [7:0]  g_s [2];
    logic [3:0]  g_ai [2];
    logic [3:0]  g_wi [2];
    logic [7:0]  g_len [2];
    int e_n, n_aw, n_w, pend_b, n_b, cyc, aw_wait, w_wait;
    int last_b_cyc, done_cyc, aw1_cyc, w0_cyc, busy_ready, both_v, taken;
    logic [31:0] base;
    e_d = '{64'h0, 64'h0};
    e_s = '{8'h0, 8'h0};
    for (int i = 0; i < (1 << sz); i++) begin
      int pos = int'(a[2:0]) + i;
      if (pos < 8) begin
        e_s[0][pos] = 1'b1;
        e_d[0][pos*8 +: 8] = d[i*8 +: 8];
      end else begin
        e_s[1][pos-8] = 1'b1;
        e_d[1][(pos-8)*8 +: 8] = d[i*8 +: 8];
      end
    end
    e_n  = (e_s[1] != 8'h0) ? 2 : 1;
    base = {a[31:3], 3'b000};
    n_aw = 0; n_w = 0; pend_b = 0; n_b = 0; cyc = 0; aw_wait = 0; w_wait = 0;
    last_b_cyc = -1; done_cyc = -1; aw1_cyc = -1; w0_cyc = -1;
    busy_ready = 0; both_v = 0; taken = 0;
    @(negedge clk);
    req_addr = a; req_size = sz; req_data = d; req_valid = 1'b1;
    while (done_cyc < 0 && cyc < 300) begin
      if (taken != 0) req_valid = 1'b0;
      if (req_valid && req_ready) taken = 1;
      else if (taken != 0 && req_ready && !req_done) busy_ready++;
      if (req_done) done_cyc = cyc;
      if (aw_valid && w_valid) both_v++;
      b_valid = (pend_b > 0) && b_ready;
      if (b_valid) begin
        pend_b--; n_b++;
        last_b_cyc = cyc;
      end
      aw_ready = 1'b0;
      if (aw_valid) begin
        if (aw_wait >= stall) begin
          aw_ready = 1'b1;
          aw_wait = 0;
          if (n_aw < 2) begin
            g_a[n_aw] = aw_addr; g_ai[n_aw] = aw_id; g_len[n_aw] = aw_len;
          end
          if (n_aw == 1) aw1_cyc = cyc;
          n_aw++;
        end else aw_wait++;
      end
      w_ready = 1'b0;
      if (w_valid) begin
        if (w_wait >= stall) begin
          w_ready = 1'b1;
          w_wait = 0;
          if (n_w < 2) begin
            g_d[n_w] = w_data; g_s[n_w] = w_strb; g_wi[n_w] = w_id;
          end
          if (n_w == 0) w0_cyc = cyc;
          n_w++;
          pend_b++;
        end else w_wait++;
      end
      @(negedge clk);
      cyc++;
    end
    aw_ready = 1'b0; w_ready = 1'b0; b_valid = 1'b0; req_valid = 1'b0;
    chk(done_cyc >= 0, "R9 done seen", 64'(done_cyc), 64'd1);
    chk(n_aw == e_n && n_w == e_n, "R2/R4 transaction count", 64'(n_aw), 64'(e_n));
    for (int t = 0; t < e_n && t < n_w && t < n_aw; t++) begin
      chk(g_a[t] == base + 32'(8 * t), "R1 R4 address", 64'(g_a[t]), 64'(base + 32'(8 * t)));
      chk(g_s[t] == e_s[t], "R2 R4 lane mask", 64'(g_s[t]), 64'(e_s[t]));
      chk(g_d[t] == e_d[t], "R3 lane data", g_d[t], e_d[t]);
      chk(g_len[t] == 8'd0, "R2 length field", 64'(g_len[t]), 64'd0);
      chk(g_ai[t] == exp_id && g_wi[t] == exp_id, "R7 id", {g_ai[t], g_wi[t]}, {exp_id, exp_id});
      exp_id = exp_id + 4'd1;
    end
    chk(n_b == e_n && done_cyc == last_b_cyc + 1, "R8 R9 done after last response",
        64'(done_cyc), 64'(last_b_cyc + 1));
    chk(busy_ready == 0, "R9 ready low while busy", 64'(busy_ready), 64'd0);
    chk(both_v == 0, "R5 phases exclusive", 64'(both_v), 64'd0);
    if (e_n == 2) chk(aw1_cyc > w0_cyc, "R5 second address after first beat", 64'(aw1_cyc), 64'(w0_cyc));
    chk(!req_done, "R9 done one cycle", 64'(req_done), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R9 watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0; req_data = '0;
    aw_ready = 1'b0; w_ready = 1'b0; b_valid = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!aw_valid && !w_valid && !b_ready && !req_done && req_ready, "R10 reset outputs",
        {59'd0, aw_valid, w_valid, b_ready, req_done, req_ready}, 64'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!aw_valid && req_ready, "R10 idle after reset", {62'd0, aw_valid, req_ready}, 64'h1);
    for (int v = 0; v < NV; v++) run_write(V_ADDR[v], V_SIZE[v], V_DATA[v], V_STALL[v]);
    // R7 wrap of the 4-bit id over more aligned writes
    for (int k = 0; k < 6; k++) run_write(32'h5000 + 32'(8 * k), 2'd3, 64'h0123456789ABCDEF + 64'(k), k % 2);
    // R3 top byte of an 8-byte split landing at lane 0 of the second word
    run_write(32'h6001, 2'd3, 64'hAA00000000000055, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule